// File: doc/BRIEF.md
# Zero-Address Stack Operand Unit

This block is the operand engine of a zero-address machine. Every operand and every result lives in a small internal register stack. A command names only an operation and never an operand location. Data enters through a push command, leaves through a pop command, and functional commands work in place on the entries at the top. A swap command brings the second entry to the top when an operand is needed twice.

The block accepts one command on each clock cycle in which `cmd_valid` is high. Each command finishes in that cycle. The top-of-stack word, the last popped word and the two error flags are registered, so they show the effect of a command on the cycle after it is accepted. The full and empty flags follow the registered depth. A command that would overrun or underrun the stack changes nothing and raises an error flag for one cycle.

Top module: `stk_opunit`

## Requirements
- R1: After a synchronous active-high reset, the stack holds no entries. `stk_empty` is 1, `stk_full` is 0, both error flags are 0, and `tos_data` and `pop_data` are 0.
- R2: PUSH (opcode 4'h1) with a free slot places `cmd_data` on top. On the following cycle `tos_data` equals that word and `stk_empty` is 0. `stk_full` is 1 exactly when all 8 entries are occupied, that is, when the top index equals 7.
- R3: PUSH while `stk_full` is 1 sets `err_overflow` for one cycle and leaves the contents, depth and `tos_data` unchanged.
- R4: POP (opcode 4'h2) on a non-empty stack copies the top word to `pop_data` and removes it. `tos_data` then shows the next entry, or 0 when the stack becomes empty. POP while `stk_empty` is 1 sets `err_underflow` for one cycle and changes nothing, including `pop_data`.
- R5: The binary commands ADD (4'h4), SUB (4'h5, second entry minus top), AND (4'h6) and OR (4'h7) remove the top two entries and push a single 16-bit result, wrapping modulo 2^16. The depth drops by one.
- R6: The unary commands shift-left (4'h8, a 0 enters at bit 0 and bit 15 is lost), increment (4'h9, wrapping) and complement (4'hA) replace the top entry. The depth is unchanged.
- R7: SWAP (4'h3) exchanges the top two entries, and `tos_data` then shows the former second entry.
- R8: A binary command or SWAP with fewer than two entries present, or a unary command on an empty stack, sets `err_underflow` for one cycle and changes nothing. `err_overflow` and `err_underflow` are never high together.
- R9: A cycle with `cmd_valid` low, or a valid command with an unassigned opcode (4'h0, 4'hB to 4'hF), changes nothing, and both error flags are 0 on the next cycle.
- R10: Commands may arrive on consecutive cycles. Each command is applied to the stack left by the previous one with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe; one command per high cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_data | input | 16 | Word for PUSH |
| tos_data | output | 16 | Registered top-of-stack word (0 when empty) |
| pop_data | output | 16 | Registered word removed by the last successful POP |
| stk_full | output | 1 | All entries occupied |
| stk_empty | output | 1 | No entries present |
| err_overflow | output | 1 | Last command was a PUSH on a full stack |
| err_underflow | output | 1 | Last command lacked the operands it needed |

## Verification
The bench fills the stack to exactly eight entries and then pushes twice more. A design with an off-by-one full test would either accept a ninth word, which corrupts the bottom slot, or reject the eighth. It issues POP, SWAP, ADD and increment on an empty stack or with a single entry. A design that checks only for an empty stack would fold a stale slot into the result or move the depth below zero. Non-commutative SUB, the wrap of increment at 16'hFFFF and shift-left of 16'h8000 catch swapped operand order and carry-width mistakes. A pop down to zero checks that the top word is cleared rather than left at a stale value.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int DW_DEF    = 16;
    localparam int DEPTH_DEF = 8;

    localparam logic [3:0] OP_NOP  = 4'h0;
    localparam logic [3:0] OP_PUSH = 4'h1;
    localparam logic [3:0] OP_POP  = 4'h2;
    localparam logic [3:0] OP_SWAP = 4'h3;
    localparam logic [3:0] OP_ADD  = 4'h4;
    localparam logic [3:0] OP_SUB  = 4'h5;
    localparam logic [3:0] OP_AND  = 4'h6;
    localparam logic [3:0] OP_OR   = 4'h7;
    localparam logic [3:0] OP_SHL  = 4'h8;
    localparam logic [3:0] OP_INC  = 4'h9;
    localparam logic [3:0] OP_NOT  = 4'hA;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_PUSH,
        ACT_POP,
        ACT_SWAP,
        ACT_UNARY,
        ACT_BINARY
    } act_e;

    typedef struct packed {
        act_e       act;
        logic [3:0] fn;
        logic       ovf;
        logic       unf;
    } ctl_t;

    function automatic logic is_binary(input logic [3:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_OR);
    endfunction

    function automatic logic is_unary(input logic [3:0] op);
        return (op == OP_SHL) || (op == OP_INC) || (op == OP_NOT);
    endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          valid,
    input  logic [3:0]    op,
    input  logic [CW-1:0] count,
    output ctl_t          ctl
);

    logic has_one;
    logic has_two;
    logic is_full;

    assign has_one = (count != '0);
    assign has_two = (count >= CW'(2));
    assign is_full = (count == CW'(DEPTH));

    always_comb begin
        ctl     = '0;
        ctl.act = ACT_NONE;
        ctl.fn  = op;
        if (valid) begin
            if (op == OP_PUSH) begin
                if (is_full) ctl.ovf = 1'b1;
                else         ctl.act = ACT_PUSH;
            end else if (op == OP_POP) begin
                if (!has_one) ctl.unf = 1'b1;
                else          ctl.act = ACT_POP;
            end else if (op == OP_SWAP) begin
                if (!has_two) ctl.unf = 1'b1;
                else          ctl.act = ACT_SWAP;
            end else if (is_binary(op)) begin
                if (!has_two) ctl.unf = 1'b1;
                else          ctl.act = ACT_BINARY;
            end else if (is_unary(op)) begin
                if (!has_one) ctl.unf = 1'b1;
                else          ctl.act = ACT_UNARY;
            end
        end
    end

endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DW = DW_DEF
) (
    input  logic [3:0]    fn,
    input  logic [DW-1:0] nos,
    input  logic [DW-1:0] top,
    output logic [DW-1:0] res
);

    always_comb begin
        case (fn)
            OP_ADD:  res = nos + top;
            OP_SUB:  res = nos - top;
            OP_AND:  res = nos & top;
            OP_OR:   res = nos | top;
            OP_SHL:  res = {top[DW-2:0], 1'b0};
            OP_INC:  res = top + DW'(1);
            OP_NOT:  res = ~top;
            default: res = top;
        endcase
    end

endmodule

// File: rtl/stk_regfile.sv
module stk_regfile
    import stk_pkg::*;
#(
    parameter int DW    = DW_DEF,
    parameter int DEPTH = DEPTH_DEF,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  act_e          act,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] res,
    output logic [DW-1:0] top,
    output logic [DW-1:0] nos,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] count_q;
    logic [AW-1:0] idx_top;
    logic [AW-1:0] idx_nos;
    logic [AW-1:0] idx_new;

    assign idx_top = AW'(count_q - CW'(1));
    assign idx_nos = AW'(count_q - CW'(2));
    assign idx_new = AW'(count_q);

    assign top   = mem[idx_top];
    assign nos   = mem[idx_nos];
    assign count = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                case (act)
                    ACT_PUSH:   if (idx_new == AW'(i)) mem[i] <= wdata;
                    ACT_SWAP: begin
                        if (idx_top == AW'(i))      mem[i] <= nos;
                        else if (idx_nos == AW'(i)) mem[i] <= top;
                    end
                    ACT_UNARY:  if (idx_top == AW'(i)) mem[i] <= res;
                    ACT_BINARY: if (idx_nos == AW'(i)) mem[i] <= res;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            case (act)
                ACT_PUSH:             count_q <= count_q + CW'(1);
                ACT_POP, ACT_BINARY:  count_q <= count_q - CW'(1);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/stk_opunit.sv
module stk_opunit
    import stk_pkg::*;
#(
    parameter int DATA_W = DW_DEF,
    parameter int DEPTH  = DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic [DATA_W-1:0] tos_data,
    output logic [DATA_W-1:0] pop_data,
    output logic              stk_full,
    output logic              stk_empty,
    output logic              err_overflow,
    output logic              err_underflow
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    ctl_t              ctl;
    logic [CW-1:0]     count;
    logic [DATA_W-1:0] top;
    logic [DATA_W-1:0] nos;
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] tos_q;
    logic [DATA_W-1:0] pop_q;
    logic              ovf_q;
    logic              unf_q;

    stk_ctrl #(.DEPTH(DEPTH), .CW(CW)) ctrl_i (
        .valid (cmd_valid),
        .op    (cmd_op),
        .count (count),
        .ctl   (ctl)
    );

    stk_alu #(.DW(DATA_W)) alu_i (
        .fn  (ctl.fn),
        .nos (nos),
        .top (top),
        .res (res)
    );

    stk_regfile #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .act   (ctl.act),
        .wdata (cmd_data),
        .res   (res),
        .top   (top),
        .nos   (nos),
        .count (count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
            pop_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= ctl.ovf;
            unf_q <= ctl.unf;
            case (ctl.act)
                ACT_PUSH:   tos_q <= cmd_data;
                ACT_POP: begin
                    pop_q <= top;
                    tos_q <= (count >= CW'(2)) ? nos : '0;
                end
                ACT_SWAP:   tos_q <= nos;
                ACT_UNARY,
                ACT_BINARY: tos_q <= res;
                default: ;
            endcase
        end
    end

    assign tos_data      = tos_q;
    assign pop_data      = pop_q;
    assign err_overflow  = ovf_q;
    assign err_underflow = unf_q;
    assign stk_full      = (count == CW'(DEPTH));
    assign stk_empty     = (count == '0);

endmodule

// File: rtl/stk_opunit_chk.sv
module stk_opunit_chk
    import stk_pkg::*;
#(
    parameter int DATA_W = DW_DEF,
    parameter int DEPTH  = DEPTH_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic [DATA_W-1:0] cmd_data,
    input logic [DATA_W-1:0] tos_data,
    input logic [DATA_W-1:0] pop_data,
    input logic              stk_full,
    input logic              stk_empty,
    input logic              err_overflow,
    input logic              err_underflow
);

    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PUSH && !stk_full) |=> (tos_data == $past(cmd_data) && !stk_empty)); // R2

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(stk_full && stk_empty)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PUSH && stk_full) |=> (err_overflow && stk_full && $stable(tos_data))); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_POP && stk_empty) |=> (err_underflow && stk_empty && $stable(pop_data))); // R4

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_overflow, err_underflow})); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(tos_data) && $stable(pop_data) && $stable(stk_full)
                        && $stable(stk_empty) && !err_overflow && !err_underflow)); // R9

endmodule

bind stk_opunit stk_opunit_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/stk_opunit_tb.sv
module stk_opunit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [3:0]  cmd_op;
    logic [15:0] cmd_data;
    logic [15:0] tos_data;
    logic [15:0] pop_data;
    logic        stk_full;
    logic        stk_empty;
    logic        err_overflow;
    logic        err_underflow;

    always #10 clk = ~clk;

    stk_opunit dut_i (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .cmd_data      (cmd_data),
        .tos_data      (tos_data),
        .pop_data      (pop_data),
        .stk_full      (stk_full),
        .stk_empty     (stk_empty),
        .err_overflow  (err_overflow),
        .err_underflow (err_underflow)
    );

    int          checks   = 0;
    int          failures = 0;
    bit          done     = 0;
    logic [15:0] model [$];
    logic [15:0] exp_pop  = '0;
    bit          exp_ovf  = 0;
    bit          exp_unf  = 0;

    task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "tos_data", tos_data, (model.size() == 0) ? 16'h0 : model[$]);
        chk(tag, "pop_data", pop_data, exp_pop);
        chk(tag, "stk_full", 16'(stk_full), 16'(model.size() == 8));
        chk(tag, "stk_empty", 16'(stk_empty), 16'(model.size() == 0));
        chk(tag, "err_overflow", 16'(err_overflow), 16'(exp_ovf));
        chk(tag, "err_underflow", 16'(err_underflow), 16'(exp_unf));
    endtask

    task automatic predict(input logic [3:0] op, input logic [15:0] d);
        logic [15:0] a;
        logic [15:0] b;
        exp_ovf = 0;
        exp_unf = 0;
        case (op)
            4'h1: if (model.size() == 8) exp_ovf = 1; else model.push_back(d);
            4'h2: if (model.size() == 0) exp_unf = 1; else exp_pop = model.pop_back();
            4'h3: if (model.size() < 2) exp_unf = 1;
                  else begin
                      a = model[$ - 1];
                      model[$ - 1] = model[$];
                      model[$] = a;
                  end
            4'h4, 4'h5, 4'h6, 4'h7:
                  if (model.size() < 2) exp_unf = 1;
                  else begin
                      b = model.pop_back();
                      a = model.pop_back();
                      if (op == 4'h4)      model.push_back(a + b);
                      else if (op == 4'h5) model.push_back(a - b);
                      else if (op == 4'h6) model.push_back(a & b);
                      else                 model.push_back(a | b);
                  end
            4'h8, 4'h9, 4'hA:
                  if (model.size() == 0) exp_unf = 1;
                  else if (op == 4'h8) model[$] = model[$] * 16'd2;
                  else if (op == 4'h9) model[$] = model[$] + 16'd1;
                  else                 model[$] = model[$] ^ 16'hFFFF;
            default: ;
        endcase
    endtask

    task automatic issue(input logic [3:0] op, input logic [15:0] d, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        predict(op, d);
        @(posedge clk);
        #5;
        cmd_valid = 1'b0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_ovf = 0;
        exp_unf = 0;
        @(posedge clk);
        #5;
        compare(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst       = 1'b1;
        cmd_valid = 1'b0;
        cmd_op    = 4'h0;
        cmd_data  = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare("R1 reset");

        // Underflow cases on an empty stack
        issue(4'h2, 16'h0, "R4 pop empty");
        issue(4'h4, 16'h0, "R8 add empty");
        issue(4'h9, 16'h0, "R8 inc empty");
        issue(4'h3, 16'h0, "R8 swap empty");

        // Fill to eight entries back to back, then overflow twice
        for (int i = 0; i < 8; i++)
            issue(4'h1, 16'(16'h1000 + i * 16'h0111), "R2 R10 push");
        issue(4'h1, 16'hDEAD, "R3 push full");
        issue(4'h1, 16'hBEEF, "R3 push full again");
        issue(4'h2, 16'h0, "R4 pop after overflow");

        // Binary operations, including non-commutative SUB
        issue(4'h5, 16'h0, "R5 sub");
        issue(4'h4, 16'h0, "R5 add");
        issue(4'h1, 16'h00F0, "R2 push");
        issue(4'h6, 16'h0, "R5 and");
        issue(4'h1, 16'hA005, "R2 push");
        issue(4'h7, 16'h0, "R5 or");

        // Unary operations and their wrap cases
        issue(4'h8, 16'h0, "R6 shl");
        issue(4'hA, 16'h0, "R6 not");
        issue(4'h9, 16'h0, "R6 inc");
        issue(4'h1, 16'hFFFF, "R2 push");
        issue(4'h9, 16'h0, "R6 inc wrap");
        issue(4'h1, 16'h8000, "R2 push");
        issue(4'h8, 16'h0, "R6 shl msb out");

        // Swap, idle and unassigned opcodes
        issue(4'h1, 16'h0003, "R2 push");
        issue(4'h3, 16'h0, "R7 swap");
        issue(4'h5, 16'h0, "R5 sub after swap");
        idle("R9 idle");
        issue(4'h0, 16'h1234, "R9 nop opcode");
        issue(4'hB, 16'h1234, "R9 unassigned B");
        issue(4'hF, 16'h1234, "R9 unassigned F");

        // Drain to one entry, exercise single-entry underflows, then empty
        while (model.size() > 1) issue(4'h2, 16'h0, "R4 pop");
        issue(4'h3, 16'h0, "R8 swap one entry");
        issue(4'h7, 16'h0, "R8 or one entry");
        issue(4'hA, 16'h0, "R6 not one entry");
        issue(4'h2, 16'h0, "R4 pop to empty");
        issue(4'h2, 16'h0, "R4 pop empty again");
        issue(4'h1, 16'h5A5A, "R2 push after drain");

        finish_run();
    end

endmodule